// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block produces the two timing clocks of an audio serial port that runs as clock master. It divides a master clock into a bit clock, and then divides the bit clock into a left/right frame clock. It also emits a one-cycle frame-start strobe. Every output is a register clocked by the master clock, so all three sit in that single clock domain. No PLL or fractional synthesis takes part: the bit clock depends only on the master clock and on the ratio selection.

A 2-bit ratio select gives the ratio of master clock to sample rate (256, 384 or 512). From it the block derives a bit-clock half period of 4, 6 or 8 master cycles. A 1-bit frame-length select picks either 64 or 32 bit clocks per frame. As an example, a 2.048 MHz master clock with ratio 256 and 32-bit frames gives a 256 kHz bit clock and an 8 kHz frame clock.

Both selects are captured while reset is held. After that they are re-captured only at a frame boundary, so a frame is never cut short or stretched mid-way.

Top module: `serial_clk_master`

## Requirements
- R1: While `rst` is high at a clock edge, `bclk_o`, `fclk_o` and `frame_start_o` are low after that edge. The first frame starts with the first edge at which `rst` is low.
- R2: With ratio code 0 (256x), `bclk_o` holds each level for exactly 4 master cycles, which is master clock divided by 8.
- R3: With ratio code 1 (384x), `bclk_o` holds each level for exactly 6 master cycles, which is master clock divided by 12.
- R4: With ratio code 2 (512x), `bclk_o` holds each level for exactly 8 master cycles, which is master clock divided by 16.
- R5: Ratio code 3 is reserved and behaves exactly like code 0.
- R6: With `short_frame` = 0 a frame lasts 64 bit clocks. With `short_frame` = 1 it lasts 32 bit clocks. The frame period in master cycles is therefore 2 x half-period x bit count.
- R7: `fclk_o` is low for the first half of each frame and high for the second half. It changes level only in the master cycle where `bclk_o` falls.
- R8: `frame_start_o` is high for exactly one master cycle, in the cycle where `fclk_o` falls at each frame boundary. It does not pulse for the first frame after reset.
- R9: A change of `ratio_sel` or `short_frame` has no effect until the next frame boundary. The new setting then applies from the first cycle of the new frame.
- R10: With ratio code 0 and `short_frame` = 1, the frame period is 256 master cycles, which gives 8 kHz from a 2.048 MHz master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Master-clock-per-sample code: 0=256x, 1=384x, 2=512x, 3=reserved (as 0) |
| short_frame | input | 1 | 0: 64 bit clocks per frame, 1: 32 bit clocks per frame |
| bclk_o | output | 1 | Bit clock, 50% duty |
| fclk_o | output | 1 | Left/right frame clock, low for the left half |
| frame_start_o | output | 1 | One-cycle strobe at each frame boundary |

## Verification
Suppose the half-period counter or the captured ratio goes wrong. The next `bclk_o` transition then lands on the wrong master cycle, which shows within at most 8 cycles. A bit-index error in the frame sequencer moves the `fclk_o` edges and the strobe. The error becomes visible at the next half-frame point, so within 512 master cycles in the slowest mode. If the configuration is picked up at the wrong moment, the mismatch shows in the first half period after a mid-frame select change. For these reasons the bench compares all three outputs on every cycle against a phase model, and it also measures whole frame periods.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        RATIO_256  = 2'd0,
        RATIO_384  = 2'd1,
        RATIO_512  = 2'd2,
        RATIO_RSVD = 2'd3
    } ratio_e;

    typedef struct packed {
        ratio_e ratio;
        logic   short_frame;
    } clk_cfg_t;

endpackage

// File: rtl/scg_cfg_hold.sv
module scg_cfg_hold
    import scg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wrap,
    input  logic [1:0] ratio_in,
    input  logic       short_in,
    output clk_cfg_t   cfg
);

    clk_cfg_t cfg_d, cfg_q, cfg_in;

    always_comb begin
        cfg_in.ratio       = ratio_e'(ratio_in);
        cfg_in.short_frame = short_in;
        cfg_d = cfg_q;
        if (wrap) begin
            cfg_d = cfg_in;
        end
    end

    // Selects are captured during reset so the first frame already uses them.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/scg_bit_div.sv
module scg_bit_div
    import scg_pkg::*;
#(
    parameter int unsigned HALF_R0 = 4,
    parameter int unsigned HALF_R1 = 6,
    parameter int unsigned HALF_R2 = 8,
    parameter int unsigned CNT_W   = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_e ratio,
    output logic   bclk,
    output logic   fall_evt
);

    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(HALF_R0 - 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(HALF_R1 - 1);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(HALF_R2 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
    } div_t;

    div_t             div_d, div_q;
    logic [CNT_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        unique case (ratio)
            RATIO_384: lim = LIM1;
            RATIO_512: lim = LIM2;
            default:   lim = LIM0;   // 256x and the reserved code
        endcase
        at_lim   = (div_q.cnt == lim);
        fall_evt = at_lim && div_q.bclk;
        div_d    = div_q;
        if (at_lim) begin
            div_d.cnt  = '0;
            div_d.bclk = ~div_q.bclk;
        end else begin
            div_d.cnt  = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign bclk = div_q.bclk;

endmodule

// File: rtl/scg_frame_seq.sv
module scg_frame_seq #(
    parameter int unsigned BITS_LONG  = 64,
    parameter int unsigned BITS_SHORT = 32,
    parameter int unsigned IDX_W      = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_evt,
    input  logic short_frame,
    output logic fclk,
    output logic frame_start,
    output logic wrap
);

    localparam logic [IDX_W-1:0] LAST_L = IDX_W'(BITS_LONG - 1);
    localparam logic [IDX_W-1:0] LAST_S = IDX_W'(BITS_SHORT - 1);
    localparam logic [IDX_W-1:0] MID_L  = IDX_W'(BITS_LONG / 2 - 1);
    localparam logic [IDX_W-1:0] MID_S  = IDX_W'(BITS_SHORT / 2 - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             fclk;
        logic             strobe;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [IDX_W-1:0] last_idx, mid_idx;

    always_comb begin
        last_idx     = short_frame ? LAST_S : LAST_L;
        mid_idx      = short_frame ? MID_S  : MID_L;
        seq_d        = seq_q;
        seq_d.strobe = 1'b0;
        wrap         = 1'b0;
        if (fall_evt) begin
            if (seq_q.idx == last_idx) begin
                seq_d.idx    = '0;
                seq_d.fclk   = 1'b0;
                seq_d.strobe = 1'b1;
                wrap         = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
                if (seq_q.idx == mid_idx) begin
                    seq_d.fclk = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fclk        = seq_q.fclk;
    assign frame_start = seq_q.strobe;

endmodule

// File: rtl/serial_clk_master.sv
module serial_clk_master
    import scg_pkg::*;
#(
    parameter int unsigned HALF_R0    = 4,
    parameter int unsigned HALF_R1    = 6,
    parameter int unsigned HALF_R2    = 8,
    parameter int unsigned BITS_LONG  = 64,
    parameter int unsigned BITS_SHORT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    input  logic       short_frame,
    output logic       bclk_o,
    output logic       fclk_o,
    output logic       frame_start_o
);

    localparam int unsigned HALF_MAX =
        (HALF_R0 > HALF_R1) ? ((HALF_R0 > HALF_R2) ? HALF_R0 : HALF_R2)
                            : ((HALF_R1 > HALF_R2) ? HALF_R1 : HALF_R2);
    localparam int unsigned CNT_W = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
    localparam int unsigned IDX_W = $clog2(BITS_LONG);

    clk_cfg_t cfg;
    logic     fall_evt;
    logic     wrap;

    scg_cfg_hold u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .ratio_in (ratio_sel),
        .short_in (short_frame),
        .cfg      (cfg)
    );

    scg_bit_div #(
        .HALF_R0 (HALF_R0),
        .HALF_R1 (HALF_R1),
        .HALF_R2 (HALF_R2),
        .CNT_W   (CNT_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .ratio    (cfg.ratio),
        .bclk     (bclk_o),
        .fall_evt (fall_evt)
    );

    scg_frame_seq #(
        .BITS_LONG  (BITS_LONG),
        .BITS_SHORT (BITS_SHORT),
        .IDX_W      (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fall_evt    (fall_evt),
        .short_frame (cfg.short_frame),
        .fclk        (fclk_o),
        .frame_start (frame_start_o),
        .wrap        (wrap)
    );

endmodule

// File: rtl/scg_chk.sv
module scg_chk (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic fclk,
    input logic fs
);

    logic       armed_q;
    logic       last_q;
    logic       seen_q;
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            last_q  <= 1'b0;
            seen_q  <= 1'b0;
            run_q   <= 4'd0;
        end else begin
            armed_q <= 1'b1;
            last_q  <= bclk;
            if (bclk != last_q) begin
                seen_q <= 1'b1;
                run_q  <= 4'd1;
            end else if (run_q != 4'hF) begin
                run_q  <= run_q + 4'd1;
            end
        end
    end

    // R7
    fclk_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(fclk) |-> $fell(bclk));

    // R8
    strobe_on_fclk_fall_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        fs |-> (!fclk && $past(fclk) && !bclk));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        fs |=> !fs);

    // R2
    bclk_run_max_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= 4'd8);

    // R3
    bclk_run_min_chk: assert property (@(posedge clk) disable iff (rst || !seen_q)
        (bclk != last_q) |-> (run_q >= 4'd4));

    // R1
    always_ff @(posedge clk) begin
        if (!rst && !armed_q) begin
            reset_quiet_chk: assert (!bclk && !fclk && !fs);
        end
    end

endmodule

bind serial_clk_master scg_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .bclk (bclk_o),
    .fclk (fclk_o),
    .fs   (frame_start_o)
);

// File: tb/sim_serial_clk_master.sv
module sim_serial_clk_master;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ratio = 2'd0;
    logic       short_f = 1'b0;
    logic       bclk, fclk, fs;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // phase model
    int         m_t = 0;
    logic [1:0] m_ratio = 2'd0;
    logic       m_short = 1'b0;
    logic       m_strobe = 1'b0;

    always #2 clk = ~clk;

    serial_clk_master u0 (
        .clk           (clk),
        .rst           (rst),
        .ratio_sel     (ratio),
        .short_frame   (short_f),
        .bclk_o        (bclk),
        .fclk_o        (fclk),
        .frame_start_o (fs)
    );

    function automatic int half_of(input logic [1:0] r);
        case (r)
            2'd1:    return 6;
            2'd2:    return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int bits_of(input logic s);
        return s ? 32 : 64;
    endfunction

    function automatic string ratio_tag(input logic [1:0] r);
        case (r)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One master cycle: advance the model with the inputs held over the edge, then compare.
    task automatic step();
        int    h, n;
        bit    pend;
        string tb;
        @(posedge clk);
        #1;
        if (rst) begin
            m_t = 0; m_ratio = ratio; m_short = short_f; m_strobe = 1'b0;
        end else begin
            h = half_of(m_ratio);
            n = bits_of(m_short);
            if (m_t == 2 * n * h - 1) begin
                m_t = 0; m_ratio = ratio; m_short = short_f; m_strobe = 1'b1;
            end else begin
                m_t++; m_strobe = 1'b0;
            end
        end
        h    = half_of(m_ratio);
        n    = bits_of(m_short);
        pend = (half_of(ratio) != h) || (short_f != m_short);
        if (rst) begin
            check_bit("R1", "bclk", bclk, 1'b0);
            check_bit("R1", "fclk", fclk, 1'b0);
            check_bit("R1", "strobe", fs, 1'b0);
        end else begin
            tb = pend ? "R9" : ratio_tag(m_ratio);
            check_bit(tb, "bclk", bclk, ((m_t / h) % 2) == 1);
            check_bit("R7", "fclk", fclk, m_t >= n * h);
            check_bit("R8", "strobe", fs, m_strobe);
        end
    endtask

    task automatic measure_gap(output int gap);
        gap = 0;
        do step(); while (fs !== 1'b1);
        do begin step(); gap++; end while (fs !== 1'b1);
    endtask

    initial begin
        int g;
        void'($urandom(32'd20240611));
        repeat (4) step();
        rst = 1'b0;
        step();
        check_bit("R1", "bclk first cycle", bclk, 1'b0);

        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 2; s++) begin
                ratio = 2'(r); short_f = 1'(s);
                measure_gap(g);
                measure_gap(g);
                check_int((r == 3) ? "R5" : "R6", "frame period", g,
                          2 * bits_of(1'(s)) * half_of(2'(r)));
            end
        end

        ratio = 2'd0; short_f = 1'b1;
        measure_gap(g);
        measure_gap(g);
        check_int("R10", "2.048MHz frame cycles", g, 256);

        for (int i = 0; i < 60000; i++) begin
            step();
            if ($urandom_range(299) == 0) begin
                ratio   = 2'($urandom_range(3));
                short_f = 1'($urandom_range(1));
            end
            if ($urandom_range(19999) == 0) begin
                rst = 1'b1;
                repeat (3) step();
                rst = 1'b0;
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule